// File: doc/BRIEF.md
# Four-Lane Alignment Buffer with Marker Monitor

This block sits behind four deserialised, character-decoded lanes of a serial converter link. Each lane arrives with its own skew, so the frame assembly stage cannot read the lanes side by side until they are lined up. Every lane carries periodic alignment markers (the K28.3 /A/ control character, flagged by the decoder on a per-lane marker input). Once the link reports lock, each lane counts markers and starts filling its own buffer at a programmable occurrence (first to fourth). When all four lanes have started, they are read out together, so the same marker leaves every lane on the same clock.

After that release, a shared position counter tracks where the multiframe boundary should fall. A marker read out of a lane at any other position is a miss. Two misses in a row on one lane throw the whole block back to the unaligned state, and it aligns again from fresh markers. Each lane raises its own sticky error flag if its buffer overflows while it waits for the others, or if it is read while empty. A manual mode starts all lanes at lock without waiting for markers and turns off the realignment.

Top module: `lane_aligner`

## Requirements
- R1: Lane k uses bits [k*DATA_W +: DATA_W] of the data input and output buses and bit k of the marker, valid, output-marker and error vectors. A character enters a lane only on a cycle where its valid bit is high.
- R2: While lock is low, markers are not counted. The cycle after lock is seen low, aligned is low, every buffer is empty and all marker counts are zero.
- R3: With manual mode off, sel_nth value n (0 to 3) makes a lane start on its (n+1)th marker since lock or since the last realignment. That marker and every later valid character of the lane are buffered. Aligned goes high after the edge at which the last lane starts.
- R4: While aligned and lock are high, every lane gives up one entry per clock. The entries appear registered one cycle later with out_valid high, so the selected marker of all four lanes shows on the same cycle.
- R5: A spread of up to DEPTH-1 cycles (15 by default) between the first and last lane to start causes no buffer error. This covers a skew of ±7 frame clocks.
- R6: The first released character has monitor position MF_LEN-1. The position steps by one per released cycle, modulo MF_LEN. A marker read out at position MF_LEN-1 is correctly placed.
- R7: With manual mode off, a second consecutive misplaced marker read out of one lane causes a realignment. realign is high for one cycle, and after that edge aligned is low, the buffers are empty and the marker counts restart from zero.
- R8: A correctly placed marker clears its lane's pending miss, so misplaced markers separated by a correct one never cause a realignment.
- R9: A lane's error bit sets on overflow or underflow and stays set until reset. Overflow is a write to a full lane with no read in the same cycle, and the character is dropped. Underflow is a read of an empty lane, and that lane's output data and marker are then zero.
- R10: With manual mode on, every lane starts on the first cycle lock is seen high, whatever the markers. No realignment ever occurs in this mode.
- R11: During and after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_i | input | 1 | Link lock; low clears alignment |
| sel_nth_i | input | 2 | Which marker occurrence starts a lane (0 = first) |
| manual_i | input | 1 | Start all lanes at lock, no monitoring |
| lane_data_i | input | 4*DATA_W | Decoded characters, lane 0 in low bits |
| lane_amark_i | input | 4 | Character is an alignment marker |
| lane_vld_i | input | 4 | Character present on lane |
| out_data_o | output | 4*DATA_W | Aligned characters |
| out_amark_o | output | 4 | Marker flag of aligned characters |
| out_valid_o | output | 1 | Aligned characters valid |
| aligned_o | output | 1 | All lanes started, reading in step |
| realign_o | output | 1 | One-cycle pulse when monitoring forces realignment |
| buf_err_o | output | 4 | Sticky per-lane overflow or underflow |

## Verification
Almost every internal fault in this block shows at the ports within a few cycles. A wrong start count or a wrong start pointer moves one lane's marker off the shared out_valid cycle. That lane then reports a misplaced marker, and realign pulses within two multiframes. A monitor counter that drifts also produces a false realign after two multiframes, or fails to produce one when a lane's phase is shifted. Buffer pointer errors turn up as a wrong data word on the first released cycle, or as an error bit that sets on a skew inside the allowed window. The bench models each lane as a queue and compares every output on every clock, so the first cycle of divergence is reported.

// File: rtl/lane_align_pkg.sv
// Shared constants and types for the four-lane alignment buffer.
// Assumes the link always has exactly four lanes.
package lane_align_pkg;
    localparam int LANES = 4;
    typedef logic [1:0] nth_sel_t;
endpackage

// File: rtl/lane_arm.sv
// Per-lane start logic: counts alignment markers after lock and raises
// 'armed' at the selected occurrence (or at once in manual mode).
// Assumes clr is asserted whenever lock is low or a realignment occurs.
module lane_arm
    import lane_align_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     lock,
    input  logic     manual,
    input  nth_sel_t sel_nth,
    input  logic     vld,
    input  logic     amark,
    output logic     armed,
    output logic     push
);
    logic [1:0] mark_cnt;
    logic       arm_now;
    logic       counted;

    // Marker seen on a lane that has not yet started
    assign counted = vld & amark & ~armed & ~manual;
    // Start this cycle: manual at lock, otherwise on the selected marker
    assign arm_now = lock & (manual | (counted & (mark_cnt == sel_nth)));
    // Buffer the character from the starting one onward
    assign push    = lock & vld & (armed | arm_now);

    // Track marker count and started flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mark_cnt <= '0;
            armed    <= 1'b0;
        end else if (lock) begin
            if (counted) mark_cnt <= mark_cnt + 2'd1;
            if (arm_now) armed    <= 1'b1;
        end
    end

    // R2: a lane is never started while lock is low
    a_r2_no_start_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> !armed);
    // R10: manual mode starts the lane at the first locked cycle
    a_r10_manual_start: assert property (@(posedge clk) disable iff (!rst_n)
        (manual && lock && !clr) |=> armed);
endmodule

// File: rtl/lane_fifo.sv
// Per-lane elastic buffer holding {marker, data}. Reports overflow
// (write to full without read) and underflow (read of empty) as pulses.
// Assumes DEPTH is a power of two.
module lane_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             ovf,
    output logic             unf
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr, rd_ptr;
    logic             full;
    logic             do_wr;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign do_wr = push & (~full | pop);
    assign ovf   = push & full & ~pop;
    assign unf   = pop & empty;
    assign dout  = mem[rd_ptr[AW-1:0]];

    // Advance pointers; clear empties the buffer
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
            if (do_wr)         wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Store incoming character
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr[AW-1:0]] <= din;
    end

    // R9: a dropped character leaves the write pointer where it was
    a_r9_drop_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> $stable(wr_ptr));
endmodule

// File: rtl/align_monitor.sv
// Multiframe position counter and per-lane miss tracking over the
// released stream. Flags realignment on a second consecutive miss.
// Assumes clr covers loss of lock and its own realignment output.
module align_monitor
    import lane_align_pkg::*;
#(
    parameter int MF_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pop,
    input  logic             manual,
    input  logic [LANES-1:0] head_amark,
    output logic             realign_now
);
    localparam int CW = $clog2(MF_LEN);
    localparam logic [CW-1:0] LAST = CW'(MF_LEN - 1);

    logic [CW-1:0]    pos_q, pos_cur;
    logic             run_q;
    logic [LANES-1:0] miss_q;
    logic             wrong;

    assign pos_cur     = run_q ? pos_q : LAST;
    assign wrong       = (pos_cur != LAST);
    assign realign_now = pop & ~manual & wrong & |(head_amark & miss_q);

    // Step the position per released cycle and record misses per lane
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos_q  <= '0;
            run_q  <= 1'b0;
            miss_q <= '0;
        end else if (pop) begin
            pos_q <= (pos_cur == LAST) ? '0 : pos_cur + 1'b1;
            run_q <= 1'b1;
            for (int k = 0; k < LANES; k++) begin
                if (!manual && head_amark[k]) miss_q[k] <= wrong;
            end
        end
    end

    // R10: manual mode never requests realignment
    a_r10_no_realign_manual: assert property (@(posedge clk) disable iff (!rst_n)
        manual |-> !realign_now);
endmodule

// File: rtl/lane_aligner.sv
// Top level: four lanes of start logic and buffers, common release,
// registered output stage, marker monitor and sticky buffer errors.
// Assumes one character per lane per clock when valid.
module lane_aligner
    import lane_align_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 16,
    parameter int MF_LEN = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock_i,
    input  logic [1:0]              sel_nth_i,
    input  logic                    manual_i,
    input  logic [LANES*DATA_W-1:0] lane_data_i,
    input  logic [LANES-1:0]        lane_amark_i,
    input  logic [LANES-1:0]        lane_vld_i,
    output logic [LANES*DATA_W-1:0] out_data_o,
    output logic [LANES-1:0]        out_amark_o,
    output logic                    out_valid_o,
    output logic                    aligned_o,
    output logic                    realign_o,
    output logic [LANES-1:0]        buf_err_o
);
    localparam int EW = DATA_W + 1;

    logic [LANES-1:0] armed, push, empty, ovf, unf, head_amark;
    logic [EW-1:0]    head [LANES];
    logic             pop, clr, realign_now;

    assign aligned_o = &armed;
    assign pop       = lock_i & aligned_o;
    assign clr       = ~lock_i | realign_now;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_arm u_arm (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .lock    (lock_i),
            .manual  (manual_i),
            .sel_nth (sel_nth_i),
            .vld     (lane_vld_i[k]),
            .amark   (lane_amark_i[k]),
            .armed   (armed[k]),
            .push    (push[k])
        );
        lane_fifo #(.DEPTH(DEPTH), .WIDTH(EW)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .push  (push[k]),
            .pop   (pop),
            .din   ({lane_amark_i[k], lane_data_i[k*DATA_W +: DATA_W]}),
            .dout  (head[k]),
            .empty (empty[k]),
            .ovf   (ovf[k]),
            .unf   (unf[k])
        );
        assign head_amark[k] = head[k][DATA_W] & ~empty[k];
    end

    align_monitor #(.MF_LEN(MF_LEN)) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .pop         (pop),
        .manual      (manual_i),
        .head_amark  (head_amark),
        .realign_now (realign_now)
    );

    // Register released characters; an empty lane reads as zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data_o  <= '0;
            out_amark_o <= '0;
        end else if (pop) begin
            for (int k = 0; k < LANES; k++) begin
                out_data_o[k*DATA_W +: DATA_W] <= empty[k] ? '0 : head[k][DATA_W-1:0];
                out_amark_o[k]                 <= head_amark[k];
            end
        end
    end

    // Output valid, realignment pulse and sticky error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            realign_o   <= 1'b0;
            buf_err_o   <= '0;
        end else begin
            out_valid_o <= pop;
            realign_o   <= realign_now;
            buf_err_o   <= buf_err_o | ovf | unf;
        end
    end

    // R4: output becomes valid only after all lanes were started
    a_r4_release_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> $past(aligned_o));
    // R7: realignment drops the aligned state at the next edge
    a_r7_realign_clears: assert property (@(posedge clk) disable iff (!rst_n)
        realign_now |=> !aligned_o);
    // R2: loss of lock drops the aligned state at the next edge
    a_r2_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_i |=> !aligned_o);
    // R9: error bits never clear outside reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_err_o != '0) |=> ((buf_err_o & $past(buf_err_o)) == $past(buf_err_o)));
endmodule

// File: tb/lane_aligner_bench.sv
// Self-checking bench: behavioural queue model of the four lanes,
// compared against the design outputs on every clock.
module lane_aligner_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 10;
    localparam int DP = 16;
    localparam int MF = 32;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lock_i = 1'b0;
    logic [1:0]    sel_nth_i = 2'd0;
    logic          manual_i = 1'b0;
    logic [4*W-1:0] lane_data_i = '0;
    logic [3:0]    lane_amark_i = '0;
    logic [3:0]    lane_vld_i = '0;
    logic [4*W-1:0] out_data_o;
    logic [3:0]    out_amark_o;
    logic          out_valid_o, aligned_o, realign_o;
    logic [3:0]    buf_err_o;

    lane_aligner #(.DATA_W(W), .DEPTH(DP), .MF_LEN(MF)) u_lane_aligner (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .sel_nth_i(sel_nth_i),
        .manual_i(manual_i), .lane_data_i(lane_data_i), .lane_amark_i(lane_amark_i),
        .lane_vld_i(lane_vld_i), .out_data_o(out_data_o), .out_amark_o(out_amark_o),
        .out_valid_o(out_valid_o), .aligned_o(aligned_o), .realign_o(realign_o),
        .buf_err_o(buf_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0, rl_seen = 0;
    int t = 0;
    int skew [4];
    int ph [4];
    bit extra_a [4];
    bit vld_en [4];

    // reference model state
    logic [W:0] mq [4][$];
    bit   m_armed [4];
    int   m_acnt [4];
    bit   m_miss [4];
    bit   m_run;
    int   m_cnt;
    bit   m_err [4];
    logic [W-1:0] e_data [4];
    bit   e_amark [4];
    bit   e_valid, e_realign;
    bit   pop, rl, arm, psh, allarm;
    int   cur;
    int   pre [4];
    logic [W:0] ent;
    bit   newarm [4];

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0d)", req, what, act, exp, t);
        end
    endtask

    // model: one update per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin
                mq[k].delete(); m_armed[k] = 0; m_acnt[k] = 0; m_miss[k] = 0;
                m_err[k] = 0; e_data[k] = '0; e_amark[k] = 0;
            end
            m_run = 0; m_cnt = 0; e_valid = 0; e_realign = 0;
        end else begin
            allarm = m_armed[0] && m_armed[1] && m_armed[2] && m_armed[3];
            pop = lock_i && allarm;
            rl = 0;
            cur = m_run ? m_cnt : MF - 1;
            for (int k = 0; k < 4; k++) pre[k] = mq[k].size();
            if (pop) begin
                for (int k = 0; k < 4; k++) begin
                    if (mq[k].size() == 0) begin
                        m_err[k] = 1; e_data[k] = '0; e_amark[k] = 0;
                    end else begin
                        ent = mq[k].pop_front();
                        e_data[k] = ent[W-1:0];
                        e_amark[k] = ent[W];
                        if (!manual_i && ent[W]) begin
                            if (cur == MF - 1) m_miss[k] = 0;
                            else if (m_miss[k]) rl = 1;
                            else m_miss[k] = 1;
                        end
                    end
                end
                m_cnt = (cur + 1) % MF;
                m_run = 1;
            end
            e_valid = pop;
            e_realign = rl;
            for (int k = 0; k < 4; k++) begin
                arm = 0;
                newarm[k] = m_armed[k];
                if (lock_i) begin
                    if (manual_i) arm = 1;
                    else arm = lane_vld_i[k] && lane_amark_i[k] && !m_armed[k]
                               && (m_acnt[k] == int'(sel_nth_i));
                    if (lane_vld_i[k] && lane_amark_i[k] && !m_armed[k] && !manual_i)
                        m_acnt[k] = (m_acnt[k] + 1) % 4;
                    psh = lane_vld_i[k] && (m_armed[k] || arm);
                    if (psh) begin
                        if (pre[k] == DP && !pop) m_err[k] = 1;
                        else mq[k].push_back({lane_amark_i[k], lane_data_i[k*W +: W]});
                    end
                    newarm[k] = m_armed[k] | arm;
                end
            end
            for (int k = 0; k < 4; k++) begin
                if (!lock_i || rl) begin
                    m_armed[k] = 0; m_acnt[k] = 0; m_miss[k] = 0; mq[k].delete();
                end else m_armed[k] = newarm[k];
            end
            if (!lock_i || rl) begin m_run = 0; m_cnt = 0; end
        end
    end

    // compare all outputs, then drive next inputs
    task automatic step();
        int s;
        @(negedge clk);
        cyc++;
        for (int k = 0; k < 4; k++) begin
            chk("R1", int'(out_data_o[k*W +: W]), int'(e_data[k]), "lane data");
            chk("R4", int'(out_amark_o[k]), int'(e_amark[k]), "lane marker");
            chk("R9", int'(buf_err_o[k]), int'(m_err[k]), "buffer error");
        end
        chk("R4", int'(out_valid_o), int'(e_valid), "out_valid");
        chk("R3", int'(aligned_o), int'(m_armed[0] && m_armed[1] && m_armed[2] && m_armed[3]), "aligned");
        chk("R7", int'(realign_o), int'(e_realign), "realign");
        if (realign_o) rl_seen++;
        for (int k = 0; k < 4; k++) begin
            s = t - skew[k] - ph[k];
            lane_data_i[k*W +: W] <= (s >= 0) ? W'(s + 37 * k) : '0;
            lane_amark_i[k] <= ((s >= 0) && (s % MF == MF - 1)) || extra_a[k];
            lane_vld_i[k] <= vld_en[k];
            extra_a[k] = 0;
        end
        t++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset(input int s0, input int s1, input int s2, input int s3);
        skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
        for (int k = 0; k < 4; k++) begin ph[k] = 0; extra_a[k] = 0; vld_en[k] = 1; end
        rst_n = 0; lock_i = 0; manual_i = 0; t = 0;
        run(3);
        rst_n = 1;
    endtask

    task automatic inject_extra();
        int s;
        s = t - skew[0] - ph[0];
        while ((s % MF == MF - 1) || (s % MF == 0)) begin step(); s = t - skew[0] - ph[0]; end
        extra_a[0] = 1;
    endtask

    initial begin
        do_reset(0, 3, 7, 1);
        // R11: reset state
        chk("R11", int'(out_valid_o), 0, "reset valid");
        chk("R11", int'(buf_err_o), 0, "reset errors");
        chk("R11", int'(out_data_o != '0), 0, "reset data");
        chk("R11", int'(aligned_o), 0, "reset aligned");

        // first marker, moderate skew
        sel_nth_i = 2'd0;
        run(5); lock_i = 1;
        rl_seen = 0;
        run(300);
        chk("R3", int'(aligned_o), 1, "aligned after first marker");
        chk("R5", int'(buf_err_o), 0, "no error at skew 7");
        chk("R6", rl_seen, 0, "no realign with correct positions");

        // fourth marker, skew 14
        do_reset(14, 0, 9, 5);
        sel_nth_i = 2'd3;
        run(2); lock_i = 1;
        rl_seen = 0;
        run(100);
        chk("R3", int'(aligned_o), 0, "not aligned before fourth marker");
        run(300);
        chk("R3", int'(aligned_o), 1, "aligned after fourth marker");
        chk("R5", int'(buf_err_o), 0, "no error at skew 14");
        chk("R6", rl_seen, 0, "monitor quiet");

        // lock loss and relock on second marker
        lock_i = 0;
        run(3);
        chk("R2", int'(aligned_o), 0, "aligned cleared by lock loss");
        lane_amark_i = 4'hF;
        run(2);
        sel_nth_i = 2'd1;
        lock_i = 1;
        run(200);
        chk("R2", int'(aligned_o), 1, "relock aligns");

        // phase shift on lane 1 forces realignment
        rl_seen = 0;
        ph[1] = 1;
        run(150);
        chk("R7", int'(rl_seen >= 1), 1, "realign after shifted lane");
        run(150);
        chk("R7", int'(aligned_o), 1, "realigned");

        // isolated misplaced markers separated by correct ones
        rl_seen = 0;
        inject_extra();
        run(50);
        inject_extra();
        run(100);
        chk("R8", rl_seen, 0, "isolated misses ignored");

        // overflow: lane 1 twenty cycles late
        do_reset(0, 20, 0, 0);
        sel_nth_i = 2'd0;
        lock_i = 1;
        run(200);
        chk("R9", int'(buf_err_o), 4'b1101, "overflow on waiting lanes");

        // underflow: lane 2 stalls after alignment
        do_reset(0, 5, 0, 0);
        lock_i = 1;
        run(150);
        chk("R9", int'(buf_err_o), 0, "clean before stall");
        vld_en[2] = 0;
        run(30);
        vld_en[2] = 1;
        run(5);
        chk("R9", int'(buf_err_o[2]), 1, "underflow on stalled lane");
        run(40);
        chk("R9", int'(buf_err_o[2]), 1, "error stays set");

        // manual mode
        do_reset(0, 3, 7, 1);
        manual_i = 1;
        lock_i = 1;
        rl_seen = 0;
        run(2);
        chk("R10", int'(aligned_o), 1, "manual start at lock");
        run(100);
        ph[2] = 3;
        run(150);
        chk("R10", rl_seen, 0, "no realign in manual mode");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule